// File: doc/BRIEF.md
# Four-Multiplier Sum-Accumulate Unit

This block multiplies four pairs of 18-bit operands in parallel and reduces the four products through a two-level adder tree. The first level combines the products two at a time into 37-bit pair sums. The second level joins the two pair sums into one 38-bit total. The total then either goes straight to the 44-bit result, or it is folded into a 44-bit running accumulator that adds or subtracts each new total.

The operands are read as two's complement or as unsigned, and this choice travels with each sample. There are two optional register stages. One sits after the pair adders and one sits at the output, and each can be switched in or out. In accumulate mode the output register doubles as the accumulator feedback register. It is always in use there, so the feedback path can never become a combinational loop. The configuration inputs (`acc_mode`, `use_pair_reg`, `use_out_reg`) are changed only while no sample is in flight.

Top module: `quad_mac_acc`

## Requirements
- R1: In plain-sum mode (`acc_mode`=0), `result` equals a0*b0 + a1*b1 + a2*b2 + a3*b3. Operand k sits in bits [18k+17:18k] of `a_ops` and `b_ops`.
- R2: With `signed_ops`=1 the operands are two's complement and the total is sign-extended to 44 bits. With `signed_ops`=0 the operands are unsigned and the total is zero-extended.
- R3: `use_pair_reg`=1 adds exactly one cycle of latency after the pair adders. With 0, that stage adds no latency.
- R4: In plain-sum mode, `use_out_reg`=1 adds one output cycle. With both stage enables at 0, `result` and `result_valid` follow the inputs in the same cycle.
- R5: In accumulate mode, each valid sample updates the accumulator to W + Z, or to W - Z when `sub_en`=1. The new value appears at `result` `use_pair_reg`+1 cycles after the sample, whatever `use_out_reg` is.
- R6: A sample with `acc_clr`=1 loads +Z, or -Z when `sub_en`=1, and discards the old accumulator value. The first sample after a change of mode must carry `acc_clr`=1.
- R7: The accumulator wraps modulo 2^44 and does not saturate.
- R8: `result_valid` is high for exactly one cycle for each valid sample, at the latency that R3 to R5 define. Cycles with `in_valid`=0 leave the accumulator and `result` unchanged.
- R9: After the synchronous reset, `result_valid` is 0 and the accumulator holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present on the operand inputs |
| signed_ops | input | 1 | 1: two's complement operands, 0: unsigned |
| acc_mode | input | 1 | 1: accumulate, 0: plain sum |
| sub_en | input | 1 | 1: subtract this total from the accumulator |
| acc_clr | input | 1 | Start the accumulator afresh with this sample |
| use_pair_reg | input | 1 | Enable the register after the pair adders |
| use_out_reg | input | 1 | Enable the output register in plain-sum mode |
| a_ops | input | 72 | Four packed first operands |
| b_ops | input | 72 | Four packed second operands |
| result | output | 44 | Sum or accumulator value |
| result_valid | output | 1 | Result qualifier |

## Verification
A table of hand-worked vectors covers the sign edges:
- small unsigned values, which show the tree wiring;
- all-ones read both ways, which separates sign extension from zero extension;
- the most negative operand squared and multiplied by the largest positive one, which reach the top of the 37-bit pair width.

Each table vector is run under all four stage-enable settings, which checks the latency of every bypass combination. Directed accumulate sequences check add and subtract, both kinds of clear, and wrap-around, including a clear-subtract that goes below zero. They also check that idle gaps leave the accumulator untouched. Random operands, signedness and add/subtract patterns in every mode and bypass setting are checked against an arithmetic model kept in 64-bit integers.

// File: rtl/qma_pkg.sv
package qma_pkg;
  localparam int N_MUL  = 4;
  localparam int N_PAIR = N_MUL / 2;

  typedef struct packed {
    logic vld;
    logic sgn;
    logic sub;
    logic clr;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/qma_pair_add.sv
module qma_pair_add #(
  parameter int OP_W   = 18,
  parameter int PAIR_W = 2 * OP_W + 1
) (
  input  logic              sgn,
  input  logic [OP_W-1:0]   a0,
  input  logic [OP_W-1:0]   b0,
  input  logic [OP_W-1:0]   a1,
  input  logic [OP_W-1:0]   b1,
  output logic [PAIR_W-1:0] pair
);
  localparam int EXT_W = PAIR_W - OP_W;

  function automatic logic [PAIR_W-1:0] widen(input logic [OP_W-1:0] x, input logic s);
    return {{EXT_W{s & x[OP_W-1]}}, x};
  endfunction

  logic [PAIR_W-1:0] prod0, prod1;

  // Modulo-2^PAIR_W products are exact: the true pair sum fits PAIR_W bits
  always_comb begin
    prod0 = widen(a0, sgn) * widen(b0, sgn);
    prod1 = widen(a1, sgn) * widen(b1, sgn);
    pair  = prod0 + prod1;
  end
endmodule

// File: rtl/qma_bypass_reg.sv
module qma_bypass_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         use_reg,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= d;
  end

  assign q = use_reg ? q_r : d;
endmodule

// File: rtl/qma_sum_acc.sv
module qma_sum_acc
  import qma_pkg::*;
#(
  parameter int PAIR_W = 37,
  parameter int TOT_W  = PAIR_W + 1,
  parameter int ACC_W  = 44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_mode,
  input  logic              use_out_reg,
  input  ctl_t              ctl,
  input  logic [PAIR_W-1:0] pair0,
  input  logic [PAIR_W-1:0] pair1,
  output logic [ACC_W-1:0]  result,
  output logic              result_valid
);
  localparam int XT_W = ACC_W - TOT_W;

  logic [TOT_W-1:0] tot;
  logic [ACC_W-1:0] tot_x, base, nxt;
  logic [ACC_W-1:0] acc_q;
  logic             vld_q;

  always_comb begin
    tot   = {ctl.sgn & pair1[PAIR_W-1], pair1} + {ctl.sgn & pair0[PAIR_W-1], pair0};
    tot_x = {{XT_W{ctl.sgn & tot[TOT_W-1]}}, tot};
    base  = ctl.clr ? '0 : acc_q;
    nxt   = ctl.sub ? base - tot_x : base + tot_x;
  end

  // One register serves as plain-mode output stage and as accumulator
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= ctl.vld;
      if (ctl.vld) acc_q <= acc_mode ? nxt : tot_x;
    end
  end

  // Feedback register is never bypassed in accumulate mode
  always_comb begin
    if (acc_mode || use_out_reg) begin
      result       = acc_q;
      result_valid = vld_q;
    end else begin
      result       = tot_x;
      result_valid = ctl.vld;
    end
  end

  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.vld |=> $stable(acc_q));

  // R6
  clr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.vld && ctl.clr && !ctl.sub && acc_mode) |=> acc_q == $past(tot_x));

  // R5
  acc_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_mode && ctl.vld) |=> vld_q);
endmodule

// File: rtl/quad_mac_acc.sv
module quad_mac_acc
  import qma_pkg::*;
#(
  parameter int OP_W  = 18,
  parameter int ACC_W = 44
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  signed_ops,
  input  logic                  acc_mode,
  input  logic                  sub_en,
  input  logic                  acc_clr,
  input  logic                  use_pair_reg,
  input  logic                  use_out_reg,
  input  logic [N_MUL*OP_W-1:0] a_ops,
  input  logic [N_MUL*OP_W-1:0] b_ops,
  output logic [ACC_W-1:0]      result,
  output logic                  result_valid
);
  localparam int PAIR_W = 2 * OP_W + 1;
  localparam int TOT_W  = PAIR_W + 1;
  localparam int BUS_W  = N_PAIR * PAIR_W;
  localparam int STG_W  = CTL_W + BUS_W;

  logic [BUS_W-1:0] pair_bus, st_bus;
  ctl_t             in_ctl, st_ctl;
  logic [STG_W-1:0] st_q;

  genvar g;
  generate
    for (g = 0; g < N_PAIR; g++) begin : g_pair
      qma_pair_add #(.OP_W(OP_W), .PAIR_W(PAIR_W)) u_pair (
        .sgn  (signed_ops),
        .a0   (a_ops[(2*g)*OP_W   +: OP_W]),
        .b0   (b_ops[(2*g)*OP_W   +: OP_W]),
        .a1   (a_ops[(2*g+1)*OP_W +: OP_W]),
        .b1   (b_ops[(2*g+1)*OP_W +: OP_W]),
        .pair (pair_bus[g*PAIR_W +: PAIR_W])
      );
    end
  endgenerate

  assign in_ctl = '{vld: in_valid, sgn: signed_ops, sub: sub_en, clr: acc_clr};

  qma_bypass_reg #(.W(STG_W)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .use_reg (use_pair_reg),
    .d       ({in_ctl, pair_bus}),
    .q       (st_q)
  );

  assign st_ctl = st_q[STG_W-1 -: CTL_W];
  assign st_bus = st_q[BUS_W-1:0];

  qma_sum_acc #(.PAIR_W(PAIR_W), .TOT_W(TOT_W), .ACC_W(ACC_W)) u_acc (
    .clk          (clk),
    .rst          (rst),
    .acc_mode     (acc_mode),
    .use_out_reg  (use_out_reg),
    .ctl          (st_ctl),
    .pair0        (st_bus[0 +: PAIR_W]),
    .pair1        (st_bus[PAIR_W +: PAIR_W]),
    .result       (result),
    .result_valid (result_valid)
  );

  // R3
  pair_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (use_pair_reg && $past(use_pair_reg) && st_ctl.vld) |-> $past(in_valid));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && acc_mode) |-> (result == '0 && !result_valid));

  // R4
  always_comb begin
    if (!rst && !acc_mode && !use_out_reg && !use_pair_reg)
      comb_path_chk: assert (result_valid == in_valid);
  end
endmodule

// File: tb/quad_mac_acc_tb.sv
module quad_mac_acc_tb;
  localparam int OPW  = 18;
  localparam int ACCW = 44;
  localparam int NV   = 5;
  localparam logic [ACCW-1:0] MASK = '1;

  // {sgn, a3..a0, b3..b0, expected plain-sum result}
  localparam logic [188:0] VEC [NV] = '{
    {1'b0, {18'd4, 18'd3, 18'd2, 18'd1}, {18'd8, 18'd7, 18'd6, 18'd5}, 44'd70},
    {1'b1, {4{18'h3FFFF}}, {4{18'd1}}, 44'hFFFFFFFFFFC},
    {1'b0, {4{18'h3FFFF}}, {4{18'h3FFFF}}, 44'h03FFFE00004},
    {1'b1, {4{18'h20000}}, {4{18'h20000}}, 44'h01000000000},
    {1'b1, {4{18'h20000}}, {4{18'h1FFFF}}, 44'hFF000080000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, signed_ops = 0, acc_mode = 1, sub_en = 0, acc_clr = 0;
  logic use_pair_reg = 0, use_out_reg = 0;
  logic [4*OPW-1:0] a_ops = '0, b_ops = '0;
  logic [ACCW-1:0] result;
  logic result_valid;
  int n_chk = 0, n_fail = 0;
  logic [ACCW-1:0] acc_ref;

  always #2 clk = ~clk;

  quad_mac_acc u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .signed_ops(signed_ops),
    .acc_mode(acc_mode), .sub_en(sub_en), .acc_clr(acc_clr),
    .use_pair_reg(use_pair_reg), .use_out_reg(use_out_reg),
    .a_ops(a_ops), .b_ops(b_ops), .result(result), .result_valid(result_valid)
  );

  task automatic check(input string req, input logic [ACCW-1:0] act, input logic [ACCW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [ACCW-1:0] model_z(input logic [71:0] a, input logic [71:0] b, input logic s);
    longint acc = 0;
    for (int i = 0; i < 4; i++) begin
      longint x, y;
      x = s ? longint'($signed(a[i*OPW +: OPW])) : longint'({46'b0, a[i*OPW +: OPW]});
      y = s ? longint'($signed(b[i*OPW +: OPW])) : longint'({46'b0, b[i*OPW +: OPW]});
      acc += x * y;
    end
    return acc[ACCW-1:0];
  endfunction

  // One sample; returns result and valid at the predicted cycle
  task automatic run(input logic [71:0] a, input logic [71:0] b, input logic s,
                     input logic sb, input logic cl, input string req,
                     output logic [ACCW-1:0] got);
    int lat;
    logic gv;
    lat = int'(use_pair_reg) + (acc_mode ? 1 : int'(use_out_reg));
    @(negedge clk);
    a_ops = a; b_ops = b; signed_ops = s; sub_en = sb; acc_clr = cl; in_valid = 1'b1;
    #1;
    got = result; gv = result_valid;
    @(posedge clk); #1;
    in_valid = 1'b0; acc_clr = 1'b0; sub_en = 1'b0;
    if (lat >= 1) begin
      repeat (lat - 1) @(posedge clk);
      #1;
      got = result; gv = result_valid;
    end
    check({req, " valid at latency"}, ACCW'(gv), ACCW'(1'b1));
    @(posedge clk); #1;
    // R8: single-cycle valid pulse
    check("R8 valid pulse width", ACCW'(result_valid), '0);
  endtask

  task automatic acc_step(input logic [71:0] a, input logic [71:0] b, input logic s,
                          input logic sb, input logic cl, input string req);
    logic [ACCW-1:0] got, z;
    z = model_z(a, b, s);
    acc_ref = cl ? '0 : acc_ref;
    acc_ref = sb ? (acc_ref - z) & MASK : (acc_ref + z) & MASK;
    run(a, b, s, sb, cl, req, got);
    check(req, got, acc_ref);
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [ACCW-1:0] got, hold;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R9
    check("R9 reset result", result, '0);
    check("R9 reset valid", ACCW'(result_valid), '0);

    // Table walk: plain sum under all four stage settings (R1, R2, R3, R4)
    acc_mode = 1'b0;
    for (int cfg = 0; cfg < 4; cfg++) begin
      use_pair_reg = cfg[0];
      use_out_reg  = cfg[1];
      for (int v = 0; v < NV; v++) begin
        run(VEC[v][187:116], VEC[v][115:44], VEC[v][188], 1'b0, 1'b0,
            cfg[0] ? "R3" : "R4", got);
        check(VEC[v][188] ? "R2 signed sum" : "R1 unsigned sum", got, VEC[v][43:0]);
      end
    end

    // Same all-ones operands read both ways (R2)
    use_pair_reg = 0; use_out_reg = 0;
    run({4{18'h3FFFF}}, {4{18'h3FFFF}}, 1'b1, 1'b0, 1'b0, "R2", got);
    check("R2 all-ones signed", got, 44'd4);

    // Accumulate directed (R5, R6)
    acc_mode = 1'b1;
    for (int cfg = 0; cfg < 4; cfg++) begin
      use_pair_reg = cfg[0];
      use_out_reg  = cfg[1];
      acc_step(VEC[0][187:116], VEC[0][115:44], 1'b0, 1'b0, 1'b1, "R6 clear add");
      acc_step(VEC[0][187:116], VEC[0][115:44], 1'b0, 1'b0, 1'b0, "R5 add");
      check("R5 doubled", acc_ref, 44'd140);
      acc_step(VEC[1][187:116], VEC[1][115:44], 1'b1, 1'b1, 1'b0, "R5 subtract negative");
      check("R5 after subtract", acc_ref, 44'd144);
    end

    // Clear with subtract goes below zero, then add wraps to zero (R6, R7)
    use_pair_reg = 0; use_out_reg = 0;
    acc_step(VEC[0][187:116], VEC[0][115:44], 1'b0, 1'b1, 1'b1, "R6 clear subtract");
    check("R7 negative wrap", acc_ref, 44'hFFFFFFFFFBA);
    acc_step(VEC[0][187:116], VEC[0][115:44], 1'b0, 1'b0, 1'b0, "R7 wrap to zero");
    check("R7 zero", acc_ref, '0);
    // Many large unsigned totals overflow 44 bits (R7)
    for (int k = 0; k < 70; k++)
      acc_step(VEC[2][187:116], VEC[2][115:44], 1'b0, 1'b0, 1'b0, "R7 overflow");

    // Idle cycles leave the accumulator unchanged (R8)
    hold = result;
    @(negedge clk); a_ops = '1; b_ops = '1; sub_en = 1; acc_clr = 1;
    repeat (5) @(negedge clk);
    sub_en = 0; acc_clr = 0;
    check("R8 idle hold", result, hold);

    // Random: every mode and bypass setting (R1, R2, R5)
    for (int cfg = 0; cfg < 8; cfg++) begin
      acc_mode     = cfg[2];
      use_pair_reg = cfg[0];
      use_out_reg  = cfg[1];
      for (int n = 0; n < 40; n++) begin
        logic [71:0] ra, rb;
        logic rs, rsb, rcl;
        ra  = {$urandom, $urandom, $urandom};
        rb  = {$urandom, $urandom, $urandom};
        rs  = $urandom_range(0, 1) == 1;
        rsb = $urandom_range(0, 1) == 1;
        rcl = (n == 0) || ($urandom_range(0, 9) == 0);
        if (acc_mode) acc_step(ra, rb, rs, rsb, rcl, "R5 random accumulate");
        else begin
          run(ra, rb, rs, 1'b0, 1'b0, "R4", got);
          check("R1 random sum", got, model_z(ra, rb, rs));
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule